// File: doc/BRIEF.md
# Link Port Power Sequencer

This block powers a display link transmit port up ahead of link training and takes it down again afterwards. It owns the port's 32-bit control word. It also owns a single configuration bit that decides whether the second and third ports share lanes. On a power-up request it checks the request and applies the lane-sharing rule. It then loads the initial control word and holds off its ready indication for a fixed settling time.

While the port is up, an external training engine may rewrite the transmit-enable, auto-train and pattern fields through a narrow write path. On a power-down request the sequencer returns the port to a quiet state and asks the receiver side to shut down, at one of two depths. In the shallow depth only the receiver is turned off. In the deep depth the transmit PLL is also stopped and the receiver clock is turned off.

A request that cannot be honoured is refused as a whole and reported by a one-cycle error pulse. This covers a bad lane count, a bad port code, or a lane-sharing change while a sharing port is live.

Top module: `lps_sequencer`

## Requirements
- R1: During and after synchronous reset (rst_n low), ctl_word is 0, share_bit is 0, and ready, rx_off_req, rx_clk_off_req and err are 0.
- R2: An accepted power-up replaces ctl_word with: lane_cnt-1 in bits 21:19, enhanced framing at bit 18, PLL enable at bit 14, composite sync at bit 11 equal to has_csync, and all other bits 0. Zero in bits 31, 10 and 9:8 (pattern field, pattern 1 = 00) means transmit off, auto-train off and pattern 1.
- R3: ready rises exactly SETTLE_US*CLK_MHZ clock edges after the edge that accepts power-up, and stays high until a power-down.
- R4: When has_third is 1, an accepted power-up sets share_bit if port_sel is 2 (third port), or if port_sel is 1 (second port) with lane_cnt of 2 or less.
- R5: When has_third is 1, an accepted power-up with port_sel 1 and lane_cnt 4 clears share_bit. With port_sel 0, or with has_third 0, share_bit is left unchanged.
- R6: A power-up that would change share_bit while peer_active is nonzero is refused. err pulses for one cycle, and ctl_word, share_bit and ready keep their values.
- R7: A power-up is refused with a one-cycle err pulse, and no other output changes, in three cases: lane_cnt is not 1, 2 or 4; port_sel is 3; or port_sel is 2 while has_third is 0.
- R8: A train_wr while ready is high writes train_tx_en to bit 31, train_auto to bit 10 and train_pat to bits 9:8. A train_wr in any other state has no effect.
- R9: A power-down accepted during settling or while up clears bits 31 and 10 and sets the pattern field to 00. It keeps the PLL bit unless the request is deep, drops ready, and pulses rx_off_req for exactly one cycle.
- R10: A deep power-down (down_deep 1) also clears bit 14 and pulses rx_clk_off_req in the same cycle as rx_off_req.
- R11: up_req while the port is not off, and down_req while it is off, are ignored: no output changes and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Power-up request, one cycle |
| down_req | input | 1 | Power-down request, one cycle |
| down_deep | input | 1 | With down_req: 1 selects deep power-down |
| port_sel | input | 2 | Port code: 0 first, 1 second, 2 third, 3 invalid |
| lane_cnt | input | 3 | Lane count for power-up |
| has_third | input | 1 | Third port exists |
| has_csync | input | 1 | Composite sync select is supported |
| peer_active | input | 2 | Bit 0: second port live; bit 1: third port live |
| train_wr | input | 1 | Training engine write strobe |
| train_tx_en | input | 1 | Transmit enable value for train_wr |
| train_auto | input | 1 | Auto-train value for train_wr |
| train_pat | input | 2 | Pattern field value for train_wr |
| ctl_word | output | 32 | Port control word |
| share_bit | output | 1 | Lane-sharing configuration bit |
| ready | output | 1 | Port up and settled |
| rx_off_req | output | 1 | Receiver-off request pulse |
| rx_clk_off_req | output | 1 | Receiver clock-off request pulse |
| err | output | 1 | Refused power-up pulse |

## Verification
The bench builds the sequencer with SETTLE_US set to 1 and CLK_MHZ at 50, so the settling wait is 50 cycles instead of 5000. That short wait makes a full sweep affordable. The sweep covers every port code, all eight lane codes, both feature flags and every peer-activity pattern, with the sharing bit carried from case to case so that both of its starting values meet each rule. Each accepted case also goes through the training write and then a power-down, alternating between the two depths.

// File: rtl/lps_pkg.sv
// Package lps_pkg
// Shared types and control-word field positions for the link port power
// sequencer. Assumes a 32-bit control word.
package lps_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ON     = 2'd2
    } lps_state_e;

    localparam int WORD_W     = 32;
    localparam int LANE_W     = 3;
    localparam int BIT_TX_EN  = 31;
    localparam int LANE_LSB   = 19;
    localparam int BIT_EFRAME = 18;
    localparam int BIT_PLL    = 14;
    localparam int BIT_CSYNC  = 11;
    localparam int BIT_AUTO   = 10;
    localparam int PAT_LSB    = 8;
    localparam int PAT_W      = 2;

    localparam logic [PAT_W-1:0] PAT_FIRST = 2'd0;

    localparam logic [1:0] PORT_A = 2'd0;
    localparam logic [1:0] PORT_B = 2'd1;
    localparam logic [1:0] PORT_C = 2'd2;

    // True for the supported lane counts.
    function automatic logic lane_count_ok(input logic [LANE_W-1:0] n);
        return (n == 3'd1) || (n == 3'd2) || (n == 3'd4);
    endfunction

endpackage

// File: rtl/lps_share_rule.sv
// Module lps_share_rule
// Combinational rule for the lane-sharing bit between the second and third
// ports. Gives the value the bit should take for a power-up of the selected
// port, and flags when that change is blocked because a sharing port is live.
// Assumes the request has already been checked for a legal port code.
module lps_share_rule
    import lps_pkg::*;
(
    input  logic [1:0]        port_sel,
    input  logic [LANE_W-1:0] lane_cnt,
    input  logic              has_third,
    input  logic              cur_share,
    input  logic [1:0]        peer_active,
    output logic              tgt_share,
    output logic              change_blocked
);

    // Pick the target value of the sharing bit.
    always_comb begin
        tgt_share = cur_share;
        if (has_third) begin
            if (port_sel == PORT_C) begin
                tgt_share = 1'b1;
            end else if (port_sel == PORT_B) begin
                tgt_share = (lane_cnt <= 3'd2);
            end
        end
    end

    // A change is refused while either sharing port is live.
    always_comb begin
        change_blocked = (tgt_share != cur_share) && (peer_active != 2'b00);
    end

endmodule

// File: rtl/lps_ctl_compose.sv
// Module lps_ctl_compose
// Builds the three candidate control words: the initial power-up word, the
// word after a power-down of either depth, and the word after a training
// write. Pure combinational; the sequencer picks one.
module lps_ctl_compose
    import lps_pkg::*;
(
    input  logic [WORD_W-1:0] cur_word,
    input  logic [LANE_W-1:0] lane_cnt,
    input  logic              has_csync,
    input  logic              down_deep,
    input  logic              train_tx_en,
    input  logic              train_auto,
    input  logic [PAT_W-1:0]  train_pat,
    output logic [WORD_W-1:0] up_word,
    output logic [WORD_W-1:0] down_word,
    output logic [WORD_W-1:0] train_word
);

    // Initial word: width, framing, PLL, optional composite sync, pattern 1.
    always_comb begin
        up_word                        = '0;
        up_word[LANE_LSB +: LANE_W]    = lane_cnt - 3'd1;
        up_word[BIT_EFRAME]            = 1'b1;
        up_word[BIT_PLL]               = 1'b1;
        up_word[BIT_CSYNC]             = has_csync;
        up_word[PAT_LSB +: PAT_W]      = PAT_FIRST;
    end

    // Teardown word: transmit and auto-train off, pattern 1, PLL off if deep.
    always_comb begin
        down_word                      = cur_word;
        down_word[BIT_TX_EN]           = 1'b0;
        down_word[BIT_AUTO]            = 1'b0;
        down_word[PAT_LSB +: PAT_W]    = PAT_FIRST;
        if (down_deep) begin
            down_word[BIT_PLL]         = 1'b0;
        end
    end

    // Training write: only the fields the training engine owns.
    always_comb begin
        train_word                     = cur_word;
        train_word[BIT_TX_EN]          = train_tx_en;
        train_word[BIT_AUTO]           = train_auto;
        train_word[PAT_LSB +: PAT_W]   = train_pat;
    end

endmodule

// File: rtl/lps_settle_timer.sv
// Module lps_settle_timer
// Counts LIMIT cycles after a start strobe and raises done for one cycle in
// the last counted cycle. An abort stops the count. Assumes LIMIT >= 1.
module lps_settle_timer #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

    logic          running;
    logic [CW-1:0] cnt;

    // Run the settle counter from start until done or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (abort || done) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running) begin
            cnt     <= cnt + 1'b1;
        end
    end

    // Done in the final counted cycle.
    always_comb begin
        done = running && (cnt == LAST_V);
    end

    // R3: the settle end is a single-cycle event.
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/lps_sequencer.sv
// Module lps_sequencer
// Power sequencer for one display link transmit port. Validates power-up
// requests, applies the lane-sharing rule, loads the initial control word,
// waits SETTLE_US microseconds, then reports ready. Tears the port down at
// one of two depths on request. Assumes single-cycle request strobes and a
// clock of CLK_MHZ megahertz.
module lps_sequencer
    import lps_pkg::*;
#(
    parameter int SETTLE_US = 100,
    parameter int CLK_MHZ   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              down_req,
    input  logic              down_deep,
    input  logic [1:0]        port_sel,
    input  logic [2:0]        lane_cnt,
    input  logic              has_third,
    input  logic              has_csync,
    input  logic [1:0]        peer_active,
    input  logic              train_wr,
    input  logic              train_tx_en,
    input  logic              train_auto,
    input  logic [1:0]        train_pat,
    output logic [31:0]       ctl_word,
    output logic              share_bit,
    output logic              ready,
    output logic              rx_off_req,
    output logic              rx_clk_off_req,
    output logic              err
);

    localparam int SETTLE_CYCLES = SETTLE_US * CLK_MHZ;

    lps_state_e        state;
    logic              tgt_share;
    logic              change_blocked;
    logic              req_legal;
    logic              up_accept;
    logic              down_accept;
    logic              tmr_done;
    logic [WORD_W-1:0] up_word;
    logic [WORD_W-1:0] down_word;
    logic [WORD_W-1:0] train_word;

    lps_share_rule u_share (
        .port_sel       (port_sel),
        .lane_cnt       (lane_cnt),
        .has_third      (has_third),
        .cur_share      (share_bit),
        .peer_active    (peer_active),
        .tgt_share      (tgt_share),
        .change_blocked (change_blocked)
    );

    lps_ctl_compose u_compose (
        .cur_word    (ctl_word),
        .lane_cnt    (lane_cnt),
        .has_csync   (has_csync),
        .down_deep   (down_deep),
        .train_tx_en (train_tx_en),
        .train_auto  (train_auto),
        .train_pat   (train_pat),
        .up_word     (up_word),
        .down_word   (down_word),
        .train_word  (train_word)
    );

    lps_settle_timer #(
        .LIMIT (SETTLE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (up_accept),
        .abort (down_accept),
        .done  (tmr_done)
    );

    // Decide whether a power-up or power-down request is taken this cycle.
    always_comb begin
        req_legal   = lane_count_ok(lane_cnt) && (port_sel != 2'd3) &&
                      !((port_sel == PORT_C) && !has_third);
        up_accept   = (state == ST_OFF) && up_req && req_legal && !change_blocked;
        down_accept = (state != ST_OFF) && down_req;
    end

    // Main sequencer: state, control word, sharing bit and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_OFF;
            ctl_word       <= '0;
            share_bit      <= 1'b0;
            rx_off_req     <= 1'b0;
            rx_clk_off_req <= 1'b0;
            err            <= 1'b0;
        end else begin
            rx_off_req     <= 1'b0;
            rx_clk_off_req <= 1'b0;
            err            <= 1'b0;
            if (down_accept) begin
                ctl_word       <= down_word;
                rx_off_req     <= 1'b1;
                rx_clk_off_req <= down_deep;
                state          <= ST_OFF;
            end else begin
                case (state)
                    ST_OFF: begin
                        if (up_accept) begin
                            ctl_word  <= up_word;
                            share_bit <= tgt_share;
                            state     <= ST_SETTLE;
                        end else if (up_req) begin
                            err       <= 1'b1;
                        end
                    end
                    ST_SETTLE: begin
                        if (tmr_done) begin
                            state <= ST_ON;
                        end
                    end
                    ST_ON: begin
                        if (train_wr) begin
                            ctl_word <= train_word;
                        end
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    // Ready reflects the settled state.
    always_comb begin
        ready = (state == ST_ON);
    end

    // R10: clock-off is only requested together with receiver-off.
    assert_clkoff_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clk_off_req |-> rx_off_req);

    // R10: a deep teardown leaves the PLL bit clear.
    assert_deep_pll_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clk_off_req |-> !ctl_word[BIT_PLL]);

    // R9: receiver-off is a one-cycle pulse.
    assert_rxoff_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_off_req |=> !rx_off_req);

    // R9: after teardown, transmit and auto-train are off and pattern is 1.
    assert_down_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_off_req |-> (!ctl_word[BIT_TX_EN] && !ctl_word[BIT_AUTO] &&
                        ctl_word[PAT_LSB +: PAT_W] == PAT_FIRST && !ready));

    // R6: the sharing bit never moves while a sharing port was live.
    assert_share_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (share_bit != $past(share_bit)) |-> ($past(peer_active) == 2'b00));

    // R7: an error follows a power-up strobe and leaves the word untouched.
    assert_err_refusal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(up_req) && $stable(ctl_word)));

    // R3: a ready port always has its PLL running.
    assert_ready_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ctl_word[BIT_PLL]);

endmodule

// File: tb/test_lps_sequencer.sv
// Bench for lps_sequencer: sweeps port code, lane code, feature flags and
// peer activity, with expected words and sharing decisions computed here.
module test_lps_sequencer;

    localparam int SETTLE_US = 1;
    localparam int CLK_MHZ   = 50;
    localparam int LIMIT     = SETTLE_US * CLK_MHZ;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_req, down_req, down_deep;
    logic [1:0]  port_sel;
    logic [2:0]  lane_cnt;
    logic        has_third, has_csync;
    logic [1:0]  peer_active;
    logic        train_wr, train_tx_en, train_auto;
    logic [1:0]  train_pat;
    logic [31:0] ctl_word;
    logic        share_bit, ready, rx_off_req, rx_clk_off_req, err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] word_exp  = '0;
    logic        share_exp = 1'b0;
    int          case_idx  = 0;

    lps_sequencer #(
        .SETTLE_US (SETTLE_US),
        .CLK_MHZ   (CLK_MHZ)
    ) i_lps_sequencer (
        .clk            (clk),
        .rst_n          (rst_n),
        .up_req         (up_req),
        .down_req       (down_req),
        .down_deep      (down_deep),
        .port_sel       (port_sel),
        .lane_cnt       (lane_cnt),
        .has_third      (has_third),
        .has_csync      (has_csync),
        .peer_active    (peer_active),
        .train_wr       (train_wr),
        .train_tx_en    (train_tx_en),
        .train_auto     (train_auto),
        .train_pat      (train_pat),
        .ctl_word       (ctl_word),
        .share_bit      (share_bit),
        .ready          (ready),
        .rx_off_req     (rx_off_req),
        .rx_clk_off_req (rx_clk_off_req),
        .err            (err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic run_case(input int p, input int l, input int h,
                            input int c, input int pa);
        logic legal, tgt, blocked, deep;
        int   n;
        port_sel    = p[1:0];
        lane_cnt    = l[2:0];
        has_third   = h[0];
        has_csync   = c[0];
        peer_active = pa[1:0];
        legal = (l == 1 || l == 2 || l == 4) && (p != 3) && !(p == 2 && h == 0);
        tgt = share_exp;
        if (h == 1 && p == 2) tgt = 1'b1;
        if (h == 1 && p == 1) tgt = (l <= 2);
        blocked = (tgt != share_exp) && (pa != 0);
        up_req = 1'b1;
        step();
        up_req = 1'b0;
        if (!legal || blocked) begin
            chk(blocked && legal ? "R6" : "R7", "err", 32'(err), 32'd1);
            chk(blocked && legal ? "R6" : "R7", "word kept", ctl_word, word_exp);
            chk(blocked && legal ? "R6" : "R7", "share kept", 32'(share_bit), 32'(share_exp));
            chk("R7", "ready low", 32'(ready), 32'd0);
            return;
        end
        word_exp  = ((32'(l) - 32'd1) << 19) | (32'd1 << 18) | (32'd1 << 14) | (32'(c) << 11);
        share_exp = tgt;
        case_idx++;
        chk("R2", "no err", 32'(err), 32'd0);
        chk("R2", "up word", ctl_word, word_exp);
        chk((h == 1 && (p == 2 || (p == 1 && l <= 2))) ? "R4" : "R5", "share",
            32'(share_bit), 32'(share_exp));
        chk("R3", "ready during settle", 32'(ready), 32'd0);
        n = 0;
        while (!ready && n < LIMIT + 5) begin
            step();
            n++;
        end
        chk("R3", "settle edges", 32'(n), 32'(LIMIT));
        // R11: a second power-up while on is ignored
        up_req   = 1'b1;
        lane_cnt = (l == 1) ? 3'd2 : 3'd1;
        step();
        up_req   = 1'b0;
        chk("R11", "up ignored word", ctl_word, word_exp);
        chk("R11", "up ignored err", 32'(err), 32'd0);
        // R8: training write while on
        train_wr    = 1'b1;
        train_tx_en = 1'b1;
        train_auto  = case_idx[0];
        train_pat   = case_idx[2:1];
        step();
        train_wr    = 1'b0;
        word_exp = (word_exp & ~32'h8000_0700) | 32'h8000_0000 |
                   (32'(case_idx[0]) << 10) | (32'(case_idx[2:1]) << 8);
        chk("R8", "train word", ctl_word, word_exp);
        // R9 / R10: teardown, depth alternating
        deep      = case_idx[3];
        down_deep = deep;
        down_req  = 1'b1;
        step();
        down_req  = 1'b0;
        word_exp  = word_exp & ~32'h8000_0700;
        if (deep) word_exp = word_exp & ~32'h0000_4000;
        chk("R9", "rx off pulse", 32'(rx_off_req), 32'd1);
        chk("R10", "clk off pulse", 32'(rx_clk_off_req), 32'(deep));
        chk(deep ? "R10" : "R9", "down word", ctl_word, word_exp);
        chk("R9", "ready dropped", 32'(ready), 32'd0);
        step();
        chk("R9", "rx off ended", 32'(rx_off_req), 32'd0);
        chk("R10", "clk off ended", 32'(rx_clk_off_req), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        up_req = 0; down_req = 0; down_deep = 0;
        port_sel = 0; lane_cnt = 0; has_third = 0; has_csync = 0;
        peer_active = 0; train_wr = 0; train_tx_en = 0; train_auto = 0;
        train_pat = 0;
        repeat (5) step();
        chk("R1", "reset word", ctl_word, 32'd0);
        chk("R1", "reset flags",
            {26'd0, share_bit, ready, rx_off_req, rx_clk_off_req, err, 1'b0}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1", "post reset word", ctl_word, 32'd0);
        chk("R1", "post reset ready", 32'(ready), 32'd0);

        // R8: training write while off has no effect
        train_wr = 1'b1; train_tx_en = 1'b1; train_auto = 1'b1; train_pat = 2'd3;
        step();
        train_wr = 1'b0;
        chk("R8", "train while off", ctl_word, 32'd0);

        // R11: power-down while off produces nothing
        down_req = 1'b1; down_deep = 1'b1;
        step();
        down_req = 1'b0;
        chk("R11", "down while off rx", 32'(rx_off_req), 32'd0);
        chk("R11", "down while off clk", 32'(rx_clk_off_req), 32'd0);

        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 8; l++)
                for (int h = 0; h < 2; h++)
                    for (int c = 0; c < 2; c++)
                        for (int pa = 0; pa < 4; pa++)
                            run_case(p, l, h, c, pa);

        // R9: power-down during settling aborts the wait
        port_sel = 2'd0; lane_cnt = 3'd1; has_csync = 1'b0; peer_active = 2'd0;
        up_req = 1'b1;
        step();
        up_req = 1'b0;
        word_exp = (32'd1 << 18) | (32'd1 << 14);
        chk("R2", "abort case up word", ctl_word, word_exp);
        repeat (3) step();
        down_deep = 1'b0; down_req = 1'b1;
        step();
        down_req = 1'b0;
        chk("R9", "abort rx off", 32'(rx_off_req), 32'd1);
        chk("R9", "abort keeps pll", ctl_word, word_exp);
        repeat (LIMIT + 2) step();
        chk("R9", "abort stays down", 32'(ready), 32'd0);

        finish_run();
    end

endmodule